// File: doc/BRIEF.md
# Dual-Channel Peak Level Monitor

The block watches a voltage sample stream and a current sample stream in parallel. Each stream delivers 24-bit two's-complement samples, each marked by a valid strobe. For every valid sample the block forms a saturating magnitude. It then compares the top 16 bits of that magnitude with a programmable threshold for that channel. When the threshold is exceeded, a sticky event flag is set. Each channel has an interrupt enable, and the single interrupt output is high while any enabled flag is set.

Each channel also holds the largest magnitude seen so far in a 24-bit register. Software reads this hold register through one of two addresses. The first returns the value and leaves it unchanged. The second returns the value and clears the register in the same access. Reading the flag register returns both flags and clears them.

Top module: `dual_peak_monitor`

## Requirements
- R1: After reset, both thresholds, both enables, both flags, both hold registers and the interrupt output are zero.
- R2: The register port uses 3-bit addresses. Address 0 is the voltage threshold and address 1 is the current threshold; both hold 16 bits and read back in the low bits. Address 2 is the enable register, with bit 0 for voltage and bit 1 for current. Writes take effect at the clock edge where `reg_wr` is high.
- R3: For a valid sample, the magnitude is |sample|. The code -2^23 saturates to 0x7FFFFF.
- R4: A channel's flag is set at the clock edge of a valid sample whose magnitude bits [23:8], taken as an unsigned number, are strictly greater than that channel's threshold. Equal or smaller values leave the flag unchanged. A threshold of 0x7FFF therefore never sets the flag.
- R5: Address 3 reads the flags, with bit 0 for voltage and bit 1 for current. A read with `reg_rd` high clears both flags at that edge. If an exceeding sample arrives in the same cycle as the read, its flag stays set.
- R6: `irq` is high exactly while some flag is set whose enable bit is also set.
- R7: A channel's hold register loads the sample magnitude only when that magnitude is strictly greater than the stored value.
- R8: Addresses 4 (voltage) and 5 (current) return the hold register without changing it.
- R9: Addresses 6 (voltage) and 7 (current) return the hold register and clear it at the read edge. If a valid sample arrives on that channel in the same cycle, the register takes that sample's magnitude instead of zero.
- R10: The two channels are independent. A sample, threshold or clear on one channel never changes the other channel's flag or hold register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| v_smp | input | 24 | Voltage sample, two's complement |
| v_vld | input | 1 | Voltage sample valid |
| i_smp | input | 24 | Current sample, two's complement |
| i_vld | input | 1 | Current sample valid |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe; triggers clear side effects |
| reg_rdata | output | 24 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |

## Verification
A flag register that holds a wrong value appears on `irq` in the first cycle after the faulty edge, provided the matching enable is set. Otherwise it shows up at the next read of address 3. A hold register that took a wrong value, or missed a clear, appears at the next read of address 4 to 7. The bench reads back after every stimulus step, so a fault is reported within one or two cycles of its cause. Threshold sweeps place magnitudes one step below, at and above each threshold, with both signs, so that a comparator that is off by one or uses the wrong bits fails at the exact boundary sample.

// File: rtl/pk_pkg.sv
package pk_pkg;
  localparam int SMP_W  = 24;
  localparam int LVL_W  = 16;
  localparam int ADDR_W = 3;
  localparam int NCH    = 2;

  localparam logic [ADDR_W-1:0] A_VLVL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ILVL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_EN    = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd3;
  localparam logic [ADDR_W-1:0] A_VMAX  = 3'd4;
  localparam logic [ADDR_W-1:0] A_IMAX  = 3'd5;
  localparam logic [ADDR_W-1:0] A_VMAXC = 3'd6;
  localparam logic [ADDR_W-1:0] A_IMAXC = 3'd7;

  // saturating absolute value of a two's-complement sample
  function automatic logic [SMP_W-1:0] sat_mag(input logic [SMP_W-1:0] s);
    logic [SMP_W-1:0] r;
    if (s[SMP_W-1] && (s[SMP_W-2:0] == '0))
      r = {1'b0, {(SMP_W-1){1'b1}}};
    else if (s[SMP_W-1])
      r = (~s) + 1'b1;
    else
      r = s;
    return r;
  endfunction

  // threshold test on the upper bits of a magnitude
  function automatic logic over_level(input logic [SMP_W-1:0] m,
                                      input logic [LVL_W-1:0] lvl);
    return m[SMP_W-1 -: LVL_W] > lvl;
  endfunction
endpackage

// File: rtl/pk_channel.sv
module pk_channel
  import pk_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] smp,
  input  logic          smp_vld,
  input  logic [LW-1:0] level,
  input  logic          flag_clr,
  input  logic          peak_clr,
  output logic          flag,
  output logic [SW-1:0] peak,
  output logic          exceed,
  output logic          raise
);
  logic [SW-1:0] mag;
  logic [SW-1:0] peak_nx;
  logic          flag_nx;

  assign mag    = sat_mag(smp);
  assign exceed = smp_vld && over_level(mag, level);
  assign raise  = smp_vld && (mag > peak);

  always_comb begin
    peak_nx = peak;
    if (peak_clr)
      peak_nx = smp_vld ? mag : '0;
    else if (raise)
      peak_nx = mag;
  end

  assign flag_nx = (flag && !flag_clr) || exceed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak <= '0;
      flag <= 1'b0;
    end else begin
      peak <= peak_nx;
      flag <= flag_nx;
    end
  end
endmodule

// File: rtl/pk_regs.sv
module pk_regs
  import pk_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int LW = LVL_W,
  parameter int AW = ADDR_W,
  parameter int NC = NCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr,
  input  logic                   wr,
  input  logic [LW-1:0]          wdata,
  input  logic                   rd,
  input  logic [NC-1:0]          flags,
  input  logic [NC-1:0][SW-1:0]  peaks,
  output logic [NC-1:0][LW-1:0]  levels,
  output logic [NC-1:0]          enables,
  output logic                   flag_clr,
  output logic [NC-1:0]          peak_clr,
  output logic [SW-1:0]          rdata
);
  logic [NC-1:0] lvl_wr;

  genvar g;
  generate
    for (g = 0; g < NC; g++) begin : g_lvl
      assign lvl_wr[g] = wr && (addr == (A_VLVL + AW'(g)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         levels[g] <= '0;
        else if (lvl_wr[g]) levels[g] <= wdata;
      end
      assign peak_clr[g] = rd && (addr == (A_VMAXC + AW'(g)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     enables <= '0;
    else if (wr && (addr == A_EN))  enables <= wdata[NC-1:0];
  end

  assign flag_clr = rd && (addr == A_FLAG);

  always_comb begin
    rdata = '0;
    case (addr)
      A_VLVL:  rdata = SW'(levels[0]);
      A_ILVL:  rdata = SW'(levels[1]);
      A_EN:    rdata = SW'(enables);
      A_FLAG:  rdata = SW'(flags);
      A_VMAX,
      A_VMAXC: rdata = peaks[0];
      default: rdata = peaks[1];
    endcase
  end
endmodule

// File: rtl/dual_peak_monitor.sv
module dual_peak_monitor
  import pk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SMP_W-1:0]  v_smp,
  input  logic              v_vld,
  input  logic [SMP_W-1:0]  i_smp,
  input  logic              i_vld,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [LVL_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [SMP_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [NCH-1:0][SMP_W-1:0] ch_smp;
  logic [NCH-1:0]            ch_vld;
  logic [NCH-1:0][LVL_W-1:0] ch_lvl;
  logic [NCH-1:0]            ch_en;
  logic [NCH-1:0]            ch_flag;
  logic [NCH-1:0][SMP_W-1:0] ch_peak;
  logic [NCH-1:0]            ch_exceed;
  logic [NCH-1:0]            ch_raise;
  logic [NCH-1:0]            ch_pclr;
  logic                      flag_clr;

  assign ch_smp[0] = v_smp;
  assign ch_smp[1] = i_smp;
  assign ch_vld[0] = v_vld;
  assign ch_vld[1] = i_vld;

  pk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .rd(reg_rd), .flags(ch_flag), .peaks(ch_peak),
    .levels(ch_lvl), .enables(ch_en), .flag_clr(flag_clr),
    .peak_clr(ch_pclr), .rdata(reg_rdata)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      pk_channel u_ch (
        .clk(clk), .rst_n(rst_n), .smp(ch_smp[c]), .smp_vld(ch_vld[c]),
        .level(ch_lvl[c]), .flag_clr(flag_clr), .peak_clr(ch_pclr[c]),
        .flag(ch_flag[c]), .peak(ch_peak[c]), .exceed(ch_exceed[c]),
        .raise(ch_raise[c])
      );
    end
  endgenerate

  assign irq = |(ch_flag & ch_en);
endmodule

// File: rtl/pk_checker.sv
module pk_checker
  import pk_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            exceed,
  input logic [NCH-1:0]            flag,
  input logic                      flag_clr,
  input logic [NCH-1:0]            pclr,
  input logic [NCH-1:0]            vld,
  input logic [NCH-1:0][SMP_W-1:0] peak,
  input logic                      irq
);
  genvar k;
  generate
    for (k = 0; k < NCH; k++) begin : g_a
      AST_FLAG_ON_EXCEED: assert property (@(posedge clk) disable iff (!rst_n)
        exceed[k] |=> flag[k]); // R4
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[k] && !flag_clr) |=> flag[k]); // R5
      AST_PEAK_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !pclr[k] |=> (peak[k] >= $past(peak[k]))); // R7
      AST_PEAK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (pclr[k] && !vld[k]) |=> (peak[k] == '0)); // R9
      AST_PEAK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pclr[k] && !vld[k]) |=> $stable(peak[k])); // R10
    end
  endgenerate

  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag != '0)); // R6
endmodule

bind dual_peak_monitor pk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .exceed(ch_exceed), .flag(ch_flag),
  .flag_clr(flag_clr), .pclr(ch_pclr), .vld(ch_vld), .peak(ch_peak), .irq(irq)
);

// File: tb/tb_dual_peak_monitor.sv
module tb_dual_peak_monitor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] v_smp = '0, i_smp = '0;
  logic        v_vld = 1'b0, i_vld = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        irq;

  int checks = 0, failures = 0;
  int exp_vpk = 0, exp_ipk = 0;
  logic [23:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_peak_monitor dut (.*);

  function automatic int magof(input int s);
    if (s == -8388608) return 8388607;
    return (s < 0) ? -s : s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 3'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [23:0] d);
    reg_addr = 3'(a); reg_rd = 1'b1; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic peek(input int a, output logic [23:0] d);
    reg_addr = 3'(a); #1 d = reg_rdata;
  endtask

  task automatic smp(input int v, input bit vv, input int i, input bit iv);
    v_smp = 24'(v); i_smp = 24'(i); v_vld = vv; i_vld = iv;
    if (vv && magof(v) > exp_vpk) exp_vpk = magof(v);
    if (iv && magof(i) > exp_ipk) exp_ipk = magof(i);
    @(posedge clk); #1 v_vld = 1'b0; i_vld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin peek(a, rv); chk("R1", rv, 0); end
    chk("R1 irq", irq, 0);

    // R2 register writes and read back
    wr(0, 16'h1234); wr(1, 16'hBEEF); wr(2, 3);
    peek(0, rv); chk("R2 vlvl", rv, 16'h1234);
    peek(1, rv); chk("R2 ilvl", rv, 16'hBEEF);
    peek(2, rv); chk("R2 en", rv, 3);
    wr(2, 0);

    // R3/R4 threshold sweep on both signs, both channels
    begin
      int lv[5] = '{0, 1, 16'h0100, 16'h4000, 16'h7FFE};
      foreach (lv[n]) begin
        wr(0, lv[n]); wr(1, lv[n]);
        for (int d = -1; d <= 1; d++) begin
          for (int sg = 0; sg < 2; sg++) begin
            int up, m, s; bit ex;
            up = lv[n] + d;
            if (up < 0) continue;
            m = (up << 8) | (d == 1 ? 0 : 8'hFF);
            s = sg ? -m : m;
            ex = (m >> 8) > lv[n];
            smp(s, 1, s, 1);
            rd(3, rv);
            chk("R4 sweep", rv, ex ? 3 : 0);
          end
        end
      end
    end

    // R4 least sensitive threshold never trips, even on saturated code
    wr(0, 16'h7FFF); wr(1, 16'h7FFF);
    smp(-8388608, 1, 8388607, 1);
    rd(3, rv); chk("R4 max level", rv, 0);
    peek(4, rv); chk("R3 saturation", rv, 24'h7FFFFF);
    peek(5, rv); chk("R7 max hold", rv, exp_ipk);
    rd(6, rv); chk("R9 vclr ret", rv, 24'h7FFFFF);
    rd(7, rv); chk("R9 iclr ret", rv, 24'h7FFFFF);
    peek(4, rv); chk("R9 vclr zero", rv, 0);
    peek(5, rv); chk("R9 iclr zero", rv, 0);
    exp_vpk = 0; exp_ipk = 0;

    // R7 strictly greater update, R8 non-destructive read, R10 independence
    smp(1000, 1, 0, 0);
    smp(-500, 1, 0, 0);
    smp(-2000, 1, 0, 0);
    smp(1999, 1, 0, 0);
    peek(4, rv); chk("R7 vpk", rv, exp_vpk);
    rd(4, rv); chk("R8 read", rv, 2000);
    peek(4, rv); chk("R8 kept", rv, 2000);
    peek(5, rv); chk("R10 ipk untouched", rv, 0);
    smp(0, 0, -77, 1);
    peek(4, rv); chk("R10 vpk untouched", rv, 2000);
    peek(5, rv); chk("R7 ipk", rv, 77);

    // R9 coincident clear and sample
    reg_addr = 3'd6; reg_rd = 1'b1;
    v_smp = 24'(-30); v_vld = 1'b1;
    @(posedge clk); #1 reg_rd = 1'b0; v_vld = 1'b0;
    peek(4, rv); chk("R9 clr+smp", rv, 30);

    // R5/R6 flags, enables, irq, coincident read
    wr(0, 16'h0010); wr(1, 16'h0020); wr(2, 1);
    smp(0, 0, 24'h002100, 1);
    chk("R6 irq masked", irq, 0);
    peek(3, rv); chk("R5 iflag", rv, 2);
    wr(2, 2); #1 chk("R6 irq i", irq, 1);
    smp(24'h001100, 1, 0, 0);
    wr(2, 1); #1 chk("R6 irq v", irq, 1);
    reg_addr = 3'd3; reg_rd = 1'b1;
    v_smp = 24'(-24'h001200); v_vld = 1'b1;
    @(posedge clk); #1 reg_rd = 1'b0; v_vld = 1'b0;
    peek(3, rv); chk("R5 coincident", rv, 1);
    chk("R6 irq held", irq, 1);
    rd(3, rv);
    peek(3, rv); chk("R5 cleared", rv, 0);
    chk("R6 irq low", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule